// File: doc/BRIEF.md
# Keyed Software Warm-Reset Sequencer

This block produces a warm reset for one domain of a chip. Three sources can start it. The first is a 4-bit key field in the local register space, written by the domain's own processors. The second is a 4-bit key field written from an always-on companion domain. The third is an active-low external reset-request pin. A key field requests a reset only when a write moves it into the arm pattern `0110`. Any other value leaves it inert.

Once started, the sequencer first raises an isolation request toward the companion domain. It then waits for that domain to acknowledge. Only after the acknowledge does it pull the active-low warm reset down, for a fixed number of cycles. It then releases the reset and withdraws the isolation request one cycle later. A sticky status register records which source or sources asked for the reset. This register and both key fields are cleared only by power-on reset, so software can read the cause after the warm reset is over.

Top module: `swrst_ctrl`

## Requirements
- R1: After power-on reset both key fields read `1111` (local at address 0, companion at address 2, bits [3:0]), the status register at address 1 reads 0, `warm_rst_n` is 1 and `iso_req` is 0.
- R2: A bus write to address 0 that changes the local key from a value other than `0110` to `0110` raises `iso_req` at the clock edge that takes the write. A write of any other value starts nothing.
- R3: A companion-port write that changes the companion key into `0110` starts a sequence in the same way. The companion key reads back at address 2 and cannot be written from the bus.
- R4: A falling edge on `ext_rstreq_n`, seen through a two-flop synchroniser, starts a sequence; `iso_req` rises at the third clock edge after the pin goes low.
- R5: `warm_rst_n` stays 1 while `iso_req` is 1 and `iso_ack` has not been sampled high. It falls at the edge that samples `iso_ack` high, and it is never 0 while `iso_req` is 0.
- R6: `warm_rst_n` stays 0 for exactly `HOLD_CYC` cycles (default 16).
- R7: `iso_req` falls exactly one cycle after `warm_rst_n` returns to 1.
- R8: Writing `0110` again into a key that already holds `0110` does not start another sequence.
- R9: Status bit 0 records a local key request, bit 1 a companion key request and bit 2 a pin request. Each bit stays set until a bus write to address 1 with a 1 in that bit position clears it. A 0 leaves the bit alone. A request that arrives while a sequence runs sets its bit but does not restart or extend the sequence.
- R10: The key fields and the status register are unaffected by the warm reset the block itself drives; after a sequence they still hold their values.
- R11: When a request sets a status bit in the same cycle as a write-one-to-clear of that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous assert, active low |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address (0 local key, 1 status, 2 companion key) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when not reading |
| cmp_key_we | input | 1 | Companion-domain key write strobe |
| cmp_key_wdata | input | 4 | Companion-domain key write value |
| ext_rstreq_n | input | 1 | External reset request, active low, asynchronous |
| iso_ack | input | 1 | Isolation complete acknowledge from companion domain |
| iso_req | output | 1 | Isolation request to companion domain |
| warm_rst_n | output | 1 | Domain warm reset, active low |

## Verification
The hardest situations to reach from the ports are the ones where requests overlap. Examples are a second source firing while reset is already held low, and a request setting a status bit in the same cycle that software writes one to clear it. The bench builds both on purpose. It writes the companion key in the middle of the hold window and then shows that no second isolation request follows. It also drives the companion write and the status clear on the same clock edge. Random phases mix key values, with the arm pattern strongly weighted, and random acknowledge delays. A bench-side model of the previous key values predicts which writes must trigger.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
  localparam int KEY_W = 4;
  localparam logic [KEY_W-1:0] KEY_ARM  = 4'b0110;
  localparam logic [KEY_W-1:0] KEY_IDLE = 4'b1111;

  localparam int NKEY    = 2;
  localparam int SRC_LOC = 0;
  localparam int SRC_CMP = 1;
  localparam int SRC_PIN = 2;
  localparam int NSRC    = 3;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ISO  = 2'd1,
    SQ_HOLD = 2'd2,
    SQ_REL  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/swrst_keyfield.sv
module swrst_keyfield
  import swrst_pkg::*;
#(
  parameter int           W    = KEY_W,
  parameter logic [W-1:0] ARM  = KEY_ARM,
  parameter logic [W-1:0] IDLE = KEY_IDLE
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] key_q,
  output logic         arm_pulse
);

  logic [W-1:0] key_d;

  always_comb begin
    key_d = key_q;
    if (wr_en) key_d = wr_data;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     key_q <= IDLE;
    else if (wr_en) key_q <= key_d;
  end

  // a request is an entry into the arm pattern, not the level
  assign arm_pulse = wr_en && (wr_data == ARM) && (key_q != ARM);

  AST_KEY_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!por_n)
    !wr_en |=> $stable(key_q)); // R10
  AST_ARM_LANDS: assert property (@(posedge clk) disable iff (!por_n)
    arm_pulse |=> (key_q == ARM) && $past(key_q) != ARM); // R8

endmodule

// File: rtl/swrst_pinsync.sv
module swrst_pinsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic fall_pulse
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) sync_q[s] <= 1'b1;
          else        sync_q[s] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) sync_q[s] <= 1'b1;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) last_q <= 1'b1;
    else        last_q <= sync_q[STAGES-1];
  end

  assign fall_pulse = last_q & ~sync_q[STAGES-1];

  AST_PIN_ONE_SHOT: assert property (@(posedge clk) disable iff (!por_n)
    fall_pulse |=> !fall_pulse); // R4

endmodule

// File: rtl/swrst_status.sv
module swrst_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] stat_q
);

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      logic bit_en;
      logic bit_d;

      always_comb begin
        bit_en = set_vec[i] | clr_vec[i];
        bit_d  = set_vec[i];   // set dominates a simultaneous clear
      end

      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      stat_q[i] <= 1'b0;
        else if (bit_en) stat_q[i] <= bit_d;
      end

      AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        stat_q[i] && !clr_vec[i] |=> stat_q[i]); // R9
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!por_n)
        set_vec[i] |=> stat_q[i]); // R11
    end
  endgenerate

endmodule

// File: rtl/swrst_seq.sv
module swrst_seq
  import swrst_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic start,
  input  logic iso_ack,
  output logic iso_req,
  output logic warm_rst_n
);

  localparam int              CNT_W     = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             iso_q, rst_n_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      SQ_IDLE: if (start) state_d = SQ_ISO;
      SQ_ISO: begin
        if (iso_ack) begin
          state_d = SQ_HOLD;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      SQ_HOLD: begin
        if (cnt_q == HOLD_LAST) begin
          state_d = SQ_REL;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      SQ_REL:  state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q <= SQ_IDLE;
      iso_q   <= 1'b0;
      rst_n_q <= 1'b1;
    end else begin
      state_q <= state_d;
      iso_q   <= (state_d != SQ_IDLE);
      rst_n_q <= (state_d != SQ_HOLD);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign iso_req    = iso_q;
  assign warm_rst_n = rst_n_q;

  AST_ISO_COVERS_RST: assert property (@(posedge clk) disable iff (!por_n)
    !warm_rst_n |-> iso_req); // R5
  AST_RST_AFTER_ACK: assert property (@(posedge clk) disable iff (!por_n)
    $fell(warm_rst_n) |-> $past(iso_ack)); // R5
  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == SQ_HOLD) && (cnt_q != HOLD_LAST) |=> !warm_rst_n); // R6
  AST_ISO_TAIL: assert property (@(posedge clk) disable iff (!por_n)
    $rose(warm_rst_n) |-> iso_req ##1 !iso_req); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!por_n)
    start && (state_q == SQ_HOLD) |=> !iso_req || (state_q != SQ_ISO)); // R9

endmodule

// File: rtl/swrst_ctrl.sv
module swrst_ctrl
  import swrst_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int HOLD_CYC    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cmp_key_we,
  input  logic [KEY_W-1:0]  cmp_key_wdata,
  input  logic              ext_rstreq_n,
  input  logic              iso_ack,
  output logic              iso_req,
  output logic              warm_rst_n
);

  localparam logic [ADDR_W-1:0] A_LKEY = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CKEY = ADDR_W'(2);

  logic                bus_wr, bus_rd;
  logic [NKEY-1:0]     key_we;
  logic [KEY_W-1:0]    key_wd [NKEY];
  logic [KEY_W-1:0]    key_q  [NKEY];
  logic [NKEY-1:0]     key_arm;
  logic                pin_fall;
  logic [NSRC-1:0]     set_vec, clr_vec, stat_q;
  logic                start;

  always_comb begin
    bus_wr          = bus_req &  bus_we;
    bus_rd          = bus_req & ~bus_we;
    key_we[SRC_LOC] = bus_wr && (bus_addr == A_LKEY);
    key_wd[SRC_LOC] = bus_wdata[KEY_W-1:0];
    key_we[SRC_CMP] = cmp_key_we;
    key_wd[SRC_CMP] = cmp_key_wdata;
    clr_vec         = (bus_wr && (bus_addr == A_STAT)) ? bus_wdata[NSRC-1:0] : '0;
  end

  genvar g;
  generate
    for (g = 0; g < NKEY; g++) begin : g_key
      swrst_keyfield #(
        .W    (KEY_W),
        .ARM  (KEY_ARM),
        .IDLE (KEY_IDLE)
      ) u_key (
        .clk       (clk),
        .por_n     (por_n),
        .wr_en     (key_we[g]),
        .wr_data   (key_wd[g]),
        .key_q     (key_q[g]),
        .arm_pulse (key_arm[g])
      );
    end
  endgenerate

  swrst_pinsync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk        (clk),
    .por_n      (por_n),
    .pin_n      (ext_rstreq_n),
    .fall_pulse (pin_fall)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[SRC_LOC] = key_arm[SRC_LOC];
    set_vec[SRC_CMP] = key_arm[SRC_CMP];
    set_vec[SRC_PIN] = pin_fall;
    start            = |set_vec;
  end

  swrst_status #(.N(NSRC)) u_stat (
    .clk     (clk),
    .por_n   (por_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .stat_q  (stat_q)
  );

  swrst_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk        (clk),
    .por_n      (por_n),
    .start      (start),
    .iso_ack    (iso_ack),
    .iso_req    (iso_req),
    .warm_rst_n (warm_rst_n)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        A_LKEY:  bus_rdata[KEY_W-1:0] = key_q[SRC_LOC];
        A_STAT:  bus_rdata[NSRC-1:0]  = stat_q;
        A_CKEY:  bus_rdata[KEY_W-1:0] = key_q[SRC_CMP];
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_START_ISO: assert property (@(posedge clk) disable iff (!por_n)
    start && !iso_req |=> iso_req); // R2
  AST_CKEY_NO_BUS: assert property (@(posedge clk) disable iff (!por_n)
    !cmp_key_we |=> $stable(key_q[SRC_CMP])); // R3

endmodule

// File: tb/sim_swrst_ctrl.sv
module sim_swrst_ctrl;
  localparam int HOLD = 16;

  logic        clk = 1'b0;
  logic        por_n, bus_req, bus_we, cmp_key_we, ext_rstreq_n, iso_ack;
  logic [3:0]  bus_addr, cmp_key_wdata;
  logic [31:0] bus_wdata, bus_rdata;
  logic        iso_req, warm_rst_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [3:0] lprev, cprev;
  logic [2:0] exp_stat;

  always #4 clk = ~clk;

  swrst_ctrl #(.HOLD_CYC(HOLD)) u0 (
    .clk(clk), .por_n(por_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_key_we(cmp_key_we), .cmp_key_wdata(cmp_key_wdata),
    .ext_rstreq_n(ext_rstreq_n), .iso_ack(iso_ack),
    .iso_req(iso_req), .warm_rst_n(warm_rst_n));

  function automatic bit trig_exp(logic [3:0] prev, logic [3:0] val);
    return (val == 4'b0110) && (prev != 4'b0110);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus_wr(logic [3:0] a, logic [31:0] d);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_rd(logic [3:0] a, output logic [31:0] d);
    bus_req = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_req = 0;
  endtask

  // isolation phase, hold window, release tail
  task automatic run_seq(string req, int dly, bit inject);
    int n;
    chk(req, "iso_req at start", iso_req, 1);
    for (int i = 0; i < dly; i++) begin
      chk("R5", "warm_rst_n before ack", warm_rst_n, 1);
      tick();
    end
    iso_ack = 1;
    tick();
    iso_ack = 0;
    n = 0;
    while (warm_rst_n == 0 && n < 100) begin
      n++;
      if (inject && n == 3) begin cmp_key_we = 1; cmp_key_wdata = 4'b0110; end
      tick();
      cmp_key_we = 0;
    end
    chk("R6", "low cycles", n, HOLD);
    chk("R7", "iso_req at release", iso_req, 1);
    tick();
    chk("R7", "iso_req after release", iso_req, 0);
  endtask

  task automatic no_seq(string req);
    for (int i = 0; i < 4; i++) begin
      chk(req, "no sequence", iso_req, 0);
      tick();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5EED_0611));
    por_n = 0; bus_req = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    cmp_key_we = 0; cmp_key_wdata = 0; ext_rstreq_n = 1; iso_ack = 0;
    repeat (3) tick();
    por_n = 1;
    tick();

    // R1 reset state
    bus_rd(0, rd); chk("R1", "local key", int'(rd), 15);
    bus_rd(2, rd); chk("R1", "companion key", int'(rd), 15);
    bus_rd(1, rd); chk("R1", "status", int'(rd), 0);
    chk("R1", "warm_rst_n", warm_rst_n, 1);
    chk("R1", "iso_req", iso_req, 0);

    // R2 non-arm value, then arm with long ack delay
    bus_wr(0, 32'h5); no_seq("R2");
    bus_wr(0, 32'h6); run_seq("R2", 9, 0);
    // R8 re-arm of a held key
    bus_wr(0, 32'h6); no_seq("R8");
    bus_rd(1, rd); chk("R2", "status local bit", int'(rd), 1);
    // R10 registers survive the warm reset
    bus_rd(0, rd); chk("R10", "local key after seq", int'(rd), 6);
    // R9 writing zeros clears nothing
    bus_wr(1, 32'h0); bus_rd(1, rd); chk("R9", "w0 no effect", int'(rd), 1);

    // R3 + R11: companion arm in same cycle as clear of its bit
    cmp_key_we = 1; cmp_key_wdata = 4'b0110;
    bus_wr(1, 32'h2);
    cmp_key_we = 0;
    run_seq("R3", 0, 0);
    bus_rd(1, rd); chk("R11", "set beats clear", int'(rd), 3);
    bus_rd(2, rd); chk("R3", "companion key", int'(rd), 6);
    bus_wr(2, 32'h9); bus_rd(2, rd); chk("R3", "companion key not bus writable", int'(rd), 6);
    no_seq("R3");

    // R9 merge during hold, no restart
    bus_wr(1, 32'h7); bus_rd(1, rd); chk("R9", "w1c all", int'(rd), 0);
    cmp_key_we = 1; cmp_key_wdata = 4'h0; tick(); cmp_key_we = 0;
    bus_wr(0, 32'h0); no_seq("R9");
    bus_wr(0, 32'h6);
    run_seq("R9", 2, 1);
    no_seq("R9");
    bus_rd(1, rd); chk("R9", "merged status", int'(rd), 3);

    // R4 pin request
    ext_rstreq_n = 0;
    repeat (2) begin chk("R4", "sync latency", iso_req, 0); tick(); end
    tick();
    run_seq("R4", 1, 0);
    ext_rstreq_n = 1; repeat (3) tick();
    bus_rd(1, rd); chk("R4", "pin status", int'(rd), 7);
    bus_wr(1, 32'h7);

    lprev = 4'h6; cprev = 4'h6; exp_stat = 3'b000;
    for (int it = 0; it < 60; it++) begin
      int src;
      logic [3:0] val;
      bit t;
      logic [2:0] m;
      src = int'($urandom % 3);
      val = ($urandom % 2) ? 4'h6 : 4'($urandom % 16);
      t = 0;
      if (src == 0) begin
        t = trig_exp(lprev, val); lprev = val;
        bus_wr(0, {28'h0, val});
        if (t) exp_stat[0] = 1;
      end else if (src == 1) begin
        t = trig_exp(cprev, val); cprev = val;
        cmp_key_we = 1; cmp_key_wdata = val; tick(); cmp_key_we = 0;
        if (t) exp_stat[1] = 1;
      end else begin
        t = 1; exp_stat[2] = 1;
        ext_rstreq_n = 0;
        for (int i = 0; i < 6 && !iso_req; i++) tick();
      end
      if (t) run_seq(src == 0 ? "R2" : (src == 1 ? "R3" : "R4"), int'($urandom % 6), 0);
      else   no_seq("R8");
      ext_rstreq_n = 1; repeat (3) tick();
      bus_rd(1, rd); chk("R9", "random status", int'(rd), int'(exp_stat));
      m = 3'($urandom % 8);
      bus_wr(1, {29'h0, m});
      exp_stat = exp_stat & ~m;
      bus_rd(1, rd); chk("R9", "random w1c", int'(rd), int'(exp_stat));
      bus_rd(0, rd); chk("R10", "local key kept", int'(rd), int'(lprev));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule